// File: doc/BRIEF.md
# Serial Configuration Port with Status Readback

This block is the slave side of a three-wire configuration link. A host shifts 32-bit words in on a serial clock pin, most significant bit first, and then raises a load strobe. On that rising edge the block commits the word to one of fourteen configuration registers. The register is chosen by the four least significant bits of the word. Address codes 14 and 15 select nothing, and a word carrying either code is dropped. While the chip-enable input is low, every serial clock and strobe edge is ignored.

The same pins also carry a status readback. The host arms it by writing register 7 with bit 8 set. Bits 6..4 of that word pick one of several 16-bit status words, and the block captures a snapshot of the chosen word at the strobe edge. While the strobe is held high, each following serial clock edge drives the next bit onto the output:

- the first edge drives a dummy zero bit;
- edges two to seventeen drive the status word, most significant bit first;
- the eighteenth edge turns the output driver off.

If the strobe drops before the sequence ends, readback stops and the driver turns off at once.

The pins `ser_clk`, `ser_load` and `ser_data` are assumed to be already synchronous to `clk`, which samples them and detects their edges. The three-state output is modelled as a data bit `rd_data` plus an enable `rd_oe`.

Top module: `cfg_serial_port`

## Requirements
- R1: On each rising edge of `ser_clk`, the bit on `ser_data` is shifted into the LSB end of a 32-bit word, so the first bit sent ends up at bit 31. A rising `ser_load` copies that word unchanged into the register whose index is bits 3..0 of the word.
- R2: A write changes only the register it addresses. Every other register keeps its value.
- R3: A word whose bits 3..0 are 14 or 15 changes no register and never starts a readback, even when bit 8 is set.
- R4: While `chip_en` is low:
  - `ser_clk` edges do not shift;
  - `ser_load` edges do not write;
  - any readback in progress ends, with `rd_oe` low one `clk` cycle later.
- R5: A readback is armed only by a write to address 7 with bit 8 set. Bits 6..4 of that word select the mode. A write to address 7 with bit 8 clear leaves `rd_oe` low.
- R6: After an armed write, with `ser_load` still high, the first `ser_clk` rising edge sets `rd_oe` to 1 and drives a dummy bit of 0. Edges 2 to 17 drive bits 15 down to 0 of the word selected at the strobe edge.
- R7: The 18th `ser_clk` rising edge of a readback sets `rd_oe` to 0. Further edges while `ser_load` stays high keep it at 0.
- R8: If `ser_load` falls during a readback, `rd_oe` is 0 one `clk` cycle later and the readback is abandoned.
- R9: Mode 1 (signal strength) word layout:

  | Bits | Content |
  |---|---|
  | 15..11 | zero |
  | 10..9 | `lna_gain` |
  | 8..7 | `filt_gain` |
  | 6..0 | `sig_level` |

- R10: Mode 3 (revision) always returns 16'h2008: product code 0x200 in bits 15..4 and revision 0x8 in bits 3..0.
- R11: Mode 4 (filter calibration) returns the calibration byte in bits 7..0 with the upper byte zero. The byte resets to decimal 32 and takes `cal_val` on each cycle that `cal_upd` is high.
- R12: Other mode words:
  - mode 0 returns `afc_val` unchanged;
  - mode 2 returns `adc_val` in bits 6..0 with the rest zero;
  - modes 5 to 7 return zero.
- R13: After reset all registers read 0 and `rd_oe` is 0. Whenever `rd_oe` is 0, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | Interface enable; low makes the port ignore all pin activity |
| ser_clk | input | 1 | Serial clock from the host |
| ser_data | input | 1 | Serial write data, MSB first |
| ser_load | input | 1 | Load strobe; rising edge commits, high level holds the readback window |
| afc_val | input | 16 | Signed frequency-offset measurement (mode 0) |
| sig_level | input | 7 | Received signal level (mode 1) |
| filt_gain | input | 2 | Current filter gain code (mode 1) |
| lna_gain | input | 2 | Current front-end gain code (mode 1) |
| adc_val | input | 7 | Converter result (mode 2) |
| cal_upd | input | 1 | Loads a new filter calibration byte |
| cal_val | input | 8 | New filter calibration byte |
| rd_data | output | 1 | Serial readback bit |
| rd_oe | output | 1 | Readback driver enable (low = high impedance) |
| cfg_regs | output | 448 | Fourteen 32-bit registers, register i at bits 32*i+31..32*i |

## Verification
The checker watches several rules on every cycle:
- the driver turns off within one cycle of the strobe falling or of chip-enable dropping;
- `rd_data` is quiet while the driver is off, and the first driven bit is a zero that follows a serial clock edge;
- the 18th edge turns the driver off;
- no register changes on a write to codes 14 or 15, or while the port is disabled.

Only the bench scenarios can show the rest:
- that shifted words land intact in the right register;
- the bit order and content of each readback mode;
- the reset default and update of the calibration byte;
- that bits shifted while disabled never reach a register.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 4;
  localparam int NUM_REGS   = 14;
  localparam int RB_W       = 16;
  localparam int RB_ADDR    = 7;
  localparam int RB_EN_BIT  = 8;
  localparam int MODE_LSB   = 4;
  localparam int MODE_W     = 3;
  localparam int LVL_W      = 7;
  localparam int GAIN_W     = 2;
  localparam int ADC_W      = 7;
  localparam int CAL_W      = 8;
  localparam int CAL_RST    = 32;
  localparam int RB_EDGES   = RB_W + 2;
  localparam logic [11:0] PRODUCT_CODE = 12'h200;
  localparam logic [3:0]  REVISION     = 4'h8;

  typedef enum logic [MODE_W-1:0] {
    RB_AFC    = 3'd0,
    RB_SIGNAL = 3'd1,
    RB_ADC    = 3'd2,
    RB_REV    = 3'd3,
    RB_CAL    = 3'd4
  } rb_mode_e;

  function automatic logic [RB_W-1:0] pack_signal(input logic [LVL_W-1:0] lvl,
                                                  input logic [GAIN_W-1:0] fg,
                                                  input logic [GAIN_W-1:0] lg);
    logic [RB_W-1:0] w;
    w = '0;
    w[LVL_W-1:0]                       = lvl;
    w[LVL_W +: GAIN_W]                 = fg;
    w[LVL_W+GAIN_W +: GAIN_W]          = lg;
    return w;
  endfunction

  function automatic logic [RB_W-1:0] rev_word();
    return {PRODUCT_CODE, REVISION};
  endfunction

  function automatic logic [RB_W-1:0] zext_adc(input logic [ADC_W-1:0] v);
    logic [RB_W-1:0] w;
    w = '0;
    w[ADC_W-1:0] = v;
    return w;
  endfunction

  function automatic logic [RB_W-1:0] zext_cal(input logic [CAL_W-1:0] v);
    logic [RB_W-1:0] w;
    w = '0;
    w[CAL_W-1:0] = v;
    return w;
  endfunction
endpackage

// File: rtl/cfg_edge_det.sv
module cfg_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_in,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_in;
  end

  assign rise = sig_in & ~prev_q;
endmodule

// File: rtl/cfg_shift_in.sv
module cfg_shift_in #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int W  = 32,
  parameter int N  = 14,
  parameter int AW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [W-1:0]   wdata,
  output logic [N*W-1:0] regs_flat
);
  logic [AW-1:0] waddr;
  assign waddr = wdata[AW-1:0];

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         q <= '0;
      else if (wr_en && waddr == AW'(i)) q <= wdata;
    end
    assign regs_flat[i*W +: W] = q;
  end
endmodule

// File: rtl/cfg_readback.sv
module cfg_readback
  import cfg_port_pkg::*;
#(
  parameter int CW = $clog2(RB_EDGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              load_hi,
  input  logic              arm,
  input  logic [MODE_W-1:0] mode,
  input  logic              sclk_evt,
  input  logic [RB_W-1:0]   afc_val,
  input  logic [LVL_W-1:0]  sig_level,
  input  logic [GAIN_W-1:0] filt_gain,
  input  logic [GAIN_W-1:0] lna_gain,
  input  logic [ADC_W-1:0]  adc_val,
  input  logic              cal_upd,
  input  logic [CAL_W-1:0]  cal_val,
  output logic              rd_data,
  output logic              rd_oe,
  output logic [CW-1:0]     edge_cnt
);
  logic [CAL_W-1:0] cal_q;
  logic [RB_W-1:0]  sel_word;
  logic [RB_W-1:0]  snap_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cal_q <= CAL_W'(CAL_RST);
    else if (cal_upd) cal_q <= cal_val;
  end

  always_comb begin
    case (mode)
      RB_AFC:    sel_word = afc_val;
      RB_SIGNAL: sel_word = pack_signal(sig_level, filt_gain, lna_gain);
      RB_ADC:    sel_word = zext_adc(adc_val);
      RB_REV:    sel_word = rev_word();
      RB_CAL:    sel_word = zext_cal(cal_q);
      default:   sel_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      snap_q   <= '0;
      edge_cnt <= '0;
      rd_oe    <= 1'b0;
      rd_data  <= 1'b0;
    end else if (!active || !load_hi) begin
      busy_q   <= 1'b0;
      edge_cnt <= '0;
      rd_oe    <= 1'b0;
      rd_data  <= 1'b0;
    end else if (arm) begin
      busy_q   <= 1'b1;
      snap_q   <= sel_word;
      edge_cnt <= '0;
      rd_oe    <= 1'b0;
      rd_data  <= 1'b0;
    end else if (busy_q && sclk_evt) begin
      edge_cnt <= edge_cnt + CW'(1);
      if (edge_cnt == '0) begin
        rd_oe   <= 1'b1;
        rd_data <= 1'b0;
      end else if (edge_cnt == CW'(RB_EDGES - 1)) begin
        rd_oe   <= 1'b0;
        rd_data <= 1'b0;
        busy_q  <= 1'b0;
      end else begin
        rd_data <= snap_q[RB_W-1];
        snap_q  <= {snap_q[RB_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_port_pkg::*;
#(
  parameter int REG_W  = WORD_W,
  parameter int N_REGS = NUM_REGS,
  localparam int REGS_W = REG_W * N_REGS,
  localparam int CNT_W  = $clog2(RB_EDGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load,
  input  logic [RB_W-1:0]   afc_val,
  input  logic [LVL_W-1:0]  sig_level,
  input  logic [GAIN_W-1:0] filt_gain,
  input  logic [GAIN_W-1:0] lna_gain,
  input  logic [ADC_W-1:0]  adc_val,
  input  logic              cal_upd,
  input  logic [CAL_W-1:0]  cal_val,
  output logic              rd_data,
  output logic              rd_oe,
  output logic [REGS_W-1:0] cfg_regs
);
  logic [1:0]        pin_rise;
  logic              sclk_evt;
  logic              latch_evt;
  logic [REG_W-1:0]  shift_word;
  logic [ADDR_W-1:0] latch_addr;
  logic              rb_arm;
  logic [CNT_W-1:0]  rb_cnt;

  cfg_edge_det #(.N(2)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in ({ser_load, ser_clk}),
    .rise   (pin_rise)
  );

  assign sclk_evt   = pin_rise[0] & chip_en;
  assign latch_evt  = pin_rise[1] & chip_en;
  assign latch_addr = shift_word[ADDR_W-1:0];
  assign rb_arm     = latch_evt && (latch_addr == ADDR_W'(RB_ADDR))
                      && shift_word[RB_EN_BIT];

  cfg_shift_in #(.W(REG_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sclk_evt),
    .din      (ser_data),
    .word     (shift_word)
  );

  cfg_reg_bank #(.W(REG_W), .N(N_REGS), .AW(ADDR_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (latch_evt),
    .wdata     (shift_word),
    .regs_flat (cfg_regs)
  );

  cfg_readback #(.CW(CNT_W)) u_rb (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (chip_en),
    .load_hi   (ser_load),
    .arm       (rb_arm),
    .mode      (shift_word[MODE_LSB +: MODE_W]),
    .sclk_evt  (sclk_evt),
    .afc_val   (afc_val),
    .sig_level (sig_level),
    .filt_gain (filt_gain),
    .lna_gain  (lna_gain),
    .adc_val   (adc_val),
    .cal_upd   (cal_upd),
    .cal_val   (cal_val),
    .rd_data   (rd_data),
    .rd_oe     (rd_oe),
    .edge_cnt  (rb_cnt)
  );
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
  parameter int REGS_W = 448,
  parameter int AW     = 4,
  parameter int NR     = 14,
  parameter int CW     = 5,
  parameter int LAST   = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_en,
  input logic              ser_load,
  input logic              rd_oe,
  input logic              rd_data,
  input logic [REGS_W-1:0] cfg_regs,
  input logic              latch_evt,
  input logic [AW-1:0]     latch_addr,
  input logic              sclk_evt,
  input logic [CW-1:0]     rb_cnt
);
  // R8: strobe low ends readback within one cycle
  p_load_low_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_load |=> !rd_oe);

  // R4: disable ends readback within one cycle
  p_disable_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> !rd_oe);

  // R4: no register changes while disabled
  p_disable_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> $stable(cfg_regs));

  // R3: unused codes leave every register alone
  p_bad_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt && latch_addr >= AW'(NR)) |=> $stable(cfg_regs));

  // R13: output quiet while driver off
  p_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> !rd_data);

  // R6: driver turns on only after a clock edge, with a dummy zero
  p_dummy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_oe) |-> ($past(sclk_evt) && !rd_data));

  // R7: eighteenth edge turns the driver off
  p_last_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && sclk_evt && ser_load && chip_en && rb_cnt == CW'(LAST)) |=> !rd_oe);
endmodule

bind cfg_serial_port cfg_serial_port_chk #(
  .REGS_W (REGS_W),
  .AW     (cfg_port_pkg::ADDR_W),
  .NR     (N_REGS),
  .CW     (CNT_W),
  .LAST   (cfg_port_pkg::RB_EDGES - 1)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chip_en    (chip_en),
  .ser_load   (ser_load),
  .rd_oe      (rd_oe),
  .rd_data    (rd_data),
  .cfg_regs   (cfg_regs),
  .latch_evt  (latch_evt),
  .latch_addr (latch_addr),
  .sclk_evt   (sclk_evt),
  .rb_cnt     (rb_cnt)
);

// File: tb/tb_cfg_serial_port.sv
module tb_cfg_serial_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_en = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_data = 1'b0;
  logic        ser_load = 1'b0;
  logic [15:0] afc_val = '0;
  logic [6:0]  sig_level = '0;
  logic [1:0]  filt_gain = '0;
  logic [1:0]  lna_gain = '0;
  logic [6:0]  adc_val = '0;
  logic        cal_upd = 1'b0;
  logic [7:0]  cal_val = '0;
  logic        rd_data;
  logic        rd_oe;
  logic [447:0] cfg_regs;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_serial_port dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_load(ser_load), .afc_val(afc_val),
    .sig_level(sig_level), .filt_gain(filt_gain), .lna_gain(lna_gain),
    .adc_val(adc_val), .cal_upd(cal_upd), .cal_val(cal_val),
    .rd_data(rd_data), .rd_oe(rd_oe), .cfg_regs(cfg_regs)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [15:0] afc;
    logic [6:0]  lvl;
    logic [1:0]  fg;
    logic [1:0]  lg;
    logic [6:0]  adc;
    logic [15:0] expect_w;
  } rb_vec_t;

  localparam logic [31:0] WR_VEC [8] = '{
    32'hDEADBEE0, 32'h12345671, 32'hCAFEF00D, 32'h0000A5A6,
    32'h8000000C, 32'h7FFFFFF3, 32'h55AA55A9, 32'h00000007
  };

  localparam rb_vec_t RB_VEC [5] = '{
    '{3'd0, 16'hF123, 7'h00, 2'b00, 2'b00, 7'h00, 16'hF123},
    '{3'd1, 16'hFFFF, 7'h55, 2'b10, 2'b01, 7'h7F, 16'h0355},
    '{3'd2, 16'hAAAA, 7'h7F, 2'b11, 2'b11, 7'h6B, 16'h006B},
    '{3'd3, 16'h1234, 7'h11, 2'b01, 2'b10, 7'h22, 16'h2008},
    '{3'd6, 16'hBEEF, 7'h7F, 2'b11, 2'b11, 7'h7F, 16'h0000}
  };

  function automatic logic [31:0] reg_of(input int i);
    return cfg_regs[32*i +: 32];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic edge_up();
    @(negedge clk) ser_clk = 1'b1;
    @(negedge clk);
  endtask

  task automatic edge_down();
    ser_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = w[i];
      edge_up();
      edge_down();
    end
  endtask

  task automatic load_pulse();
    @(negedge clk) ser_load = 1'b1;
    @(negedge clk);
    @(negedge clk) ser_load = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_word(input logic [31:0] w);
    send_bits(w, 32);
    load_pulse();
  endtask

  // R5/R6/R7: run a full readback and compare the collected word
  task automatic readback(input logic [2:0] mode, input logic [15:0] exp, input string tag);
    logic [15:0] got;
    logic [31:0] cw;
    bit oe_ok;
    cw = 32'h100 | (32'(mode) << 4) | 32'd7;
    send_bits(cw, 32);
    @(negedge clk) ser_load = 1'b1;
    @(negedge clk);
    check(rd_oe == 1'b0, {tag, " R5 off before first edge"}, 32'(rd_oe), 0);
    edge_up();
    check(rd_oe == 1'b1 && rd_data == 1'b0, {tag, " R6 dummy bit"},
          {30'd0, rd_oe, rd_data}, 32'h2);
    edge_down();
    oe_ok = 1;
    for (int k = 15; k >= 0; k--) begin
      edge_up();
      got[k] = rd_data;
      if (!rd_oe) oe_ok = 0;
      edge_down();
    end
    check(oe_ok, {tag, " R6 driver on for data"}, 32'(oe_ok), 1);
    check(got == exp, {tag, " word"}, 32'(got), 32'(exp));
    edge_up();
    check(rd_oe == 1'b0, {tag, " R7 off at edge 18"}, 32'(rd_oe), 0);
    edge_down();
    edge_up();
    check(rd_oe == 1'b0 && rd_data == 1'b0, {tag, " R7 stays off"},
          {30'd0, rd_oe, rd_data}, 0);
    edge_down();
    @(negedge clk) ser_load = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [447:0] snap;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13: reset state
    check(cfg_regs == '0, "R13 regs zero", cfg_regs[31:0], 0);
    check(rd_oe == 1'b0 && rd_data == 1'b0, "R13 output off",
          {30'd0, rd_oe, rd_data}, 0);

    // R1/R2: table of writes
    for (int v = 0; v < 8; v++) begin
      snap = cfg_regs;
      write_word(WR_VEC[v]);
      check(reg_of(int'(WR_VEC[v][3:0])) == WR_VEC[v], "R1 write lands",
            reg_of(int'(WR_VEC[v][3:0])), WR_VEC[v]);
      snap[32*int'(WR_VEC[v][3:0]) +: 32] = WR_VEC[v];
      check(cfg_regs == snap, "R2 others unchanged", 32'(v), 32'(v));
    end

    // R5: address 7 with enable clear does not drive
    @(negedge clk) ser_load = 1'b1;
    edge_up();
    check(rd_oe == 1'b0, "R5 no readback without enable", 32'(rd_oe), 0);
    edge_down();
    @(negedge clk) ser_load = 1'b0;
    @(negedge clk);

    // R3: codes 14 and 15 discarded, no readback even with bit 8
    snap = cfg_regs;
    write_word(32'h1234567E);
    check(cfg_regs == snap, "R3 code 14 dropped", 0, 0);
    send_bits(32'h0000010F, 32);
    @(negedge clk) ser_load = 1'b1;
    @(negedge clk);
    edge_up();
    check(rd_oe == 1'b0, "R3 code 15 no readback", 32'(rd_oe), 0);
    edge_down();
    @(negedge clk) ser_load = 1'b0;
    @(negedge clk);
    check(cfg_regs == snap, "R3 code 15 dropped", 0, 0);

    // R4: disabled write ignored
    chip_en = 1'b0;
    write_word(32'hFFFFFFF2);
    check(reg_of(2) == 32'h0, "R4 write ignored when disabled", reg_of(2), 0);
    // R4: shifts during disable ignored
    chip_en = 1'b1;
    send_bits(32'h0BADF002, 32);
    chip_en = 1'b0;
    send_bits(32'hFFFFFFFF, 8);
    chip_en = 1'b1;
    load_pulse();
    check(reg_of(2) == 32'h0BADF002, "R4 shifts ignored when disabled",
          reg_of(2), 32'h0BADF002);

    // R9/R10/R12: table of readback modes
    for (int v = 0; v < 5; v++) begin
      afc_val   = RB_VEC[v].afc;
      sig_level = RB_VEC[v].lvl;
      filt_gain = RB_VEC[v].fg;
      lna_gain  = RB_VEC[v].lg;
      adc_val   = RB_VEC[v].adc;
      readback(RB_VEC[v].mode, RB_VEC[v].expect_w, "R9 R10 R12 mode");
    end

    // R11: calibration default then update
    readback(3'd4, 16'd32, "R11 cal default");
    @(negedge clk) begin cal_val = 8'hA5; cal_upd = 1'b1; end
    @(negedge clk) cal_upd = 1'b0;
    readback(3'd4, 16'h00A5, "R11 cal updated");

    // R8: strobe drop ends readback early
    send_bits(32'h00000137, 32);
    @(negedge clk) ser_load = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin edge_up(); edge_down(); end
    check(rd_oe == 1'b1, "R8 driving mid readback", 32'(rd_oe), 1);
    @(negedge clk) ser_load = 1'b0;
    @(negedge clk);
    check(rd_oe == 1'b0 && rd_data == 1'b0, "R8 off after strobe drop",
          {30'd0, rd_oe, rd_data}, 0);
    edge_up();
    check(rd_oe == 1'b0, "R8 abandoned", 32'(rd_oe), 0);
    edge_down();

    // R4: disable during readback
    send_bits(32'h00000137, 32);
    @(negedge clk) ser_load = 1'b1;
    @(negedge clk);
    edge_up(); edge_down();
    chip_en = 1'b0;
    @(negedge clk);
    check(rd_oe == 1'b0, "R4 disable ends readback", 32'(rd_oe), 0);
    chip_en = 1'b1;
    @(negedge clk) ser_load = 1'b0;
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule